// File: doc/BRIEF.md
# Selectable Multi-Output Clock Divider Bank

This block turns one fast source clock into nine divided clocks plus a feedback clock for an external phase-locked loop. The primary output A runs at half or a quarter of the source. Three secondary groups each run at a quarter or an eighth of the source: B is one pin, C is a pair and D is a group of five. Each group has its own ratio-select bit. The feedback output runs at an eighth or a sixteenth of the source, and it closes the loop back to the phase detector. Every ratio is a power of two, so each output has an exact 50% duty cycle.

All outputs are taken from one shared free-running counter. As a result, every rising edge lines up with the counter wrap. A reference multiplexer picks the test clock or the crystal clock. A bypass multiplexer lets that reference drive the dividers in place of the oscillator clock. One master-reset/output-enable input clears every divider flop and puts the nine clock pins in high impedance. A new ratio select is taken only at the wrap of the slowest period, so no runt pulse can appear.

Top module: `clk_div_bank`

## Requirements
- R1: The primary output `qa_o` runs at source/2 when `sel_i[3]` is 0 and at source/4 when it is 1.
- R2: `qb_o` runs at source/4 when `sel_i[2]` is 0 and at source/8 when it is 1.
- R3: Both pins of `qc_o` run at source/4 when `sel_i[1]` is 0 and at source/8 when it is 1.
- R4: All five pins of `qd_o` run at source/4 when `sel_i[0]` is 0 and at source/8 when it is 1.
- R5: `fb_o` runs at source/8 when `fb_sel_i` is 1 and at source/16 when it is 0.
- R6: Every output has a 50% duty cycle. Every output goes high on the first source rising edge after release. After that, every output whose period divides a multiple of 16 source cycles goes high again on each 16-cycle boundary.
- R7: While `mr_oe_i` is 1, the nine clock pins are high impedance, `fb_o` is 0 and the counter is held. After `mr_oe_i` falls, counting restarts from the first source edge.
- R8: When `pll_en_i` is 0, the selected reference clock drives the dividers in place of `vco_clk_i`. When `pll_en_i` is 1, `vco_clk_i` drives them.
- R9: `ref_clk_o` carries `test_clk_i` when `ref_sel_i` is 1 and `xtal_clk_i` when it is 0. This holds whether or not the dividers are bypassed.
- R10: A change on `sel_i` or `fb_sel_i` takes effect only on a 16-cycle boundary. Between boundaries, every output keeps the ratio latched at the last boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| vco_clk_i | input | 1 | Fast oscillator source clock |
| xtal_clk_i | input | 1 | Crystal reference clock |
| test_clk_i | input | 1 | Test reference clock |
| ref_sel_i | input | 1 | 1 = test clock is the reference, 0 = crystal |
| pll_en_i | input | 1 | 0 = reference drives the dividers (bypass) |
| mr_oe_i | input | 1 | 1 = hold reset and float the clock pins |
| fb_sel_i | input | 1 | Feedback ratio: 1 = /8, 0 = /16 |
| sel_i | input | 4 | Ratio selects: bit 3 = A, bit 2 = B, bit 1 = C, bit 0 = D |
| ref_clk_o | output | 1 | Selected reference clock |
| fb_o | output | 1 | Feedback clock |
| qa_o | output | 1 | Primary clock output |
| qb_o | output | 1 | Secondary output B |
| qc_o | output | NUM_C | Secondary pair C |
| qd_o | output | NUM_D | Secondary group D |

## Verification
The hardest case to reach from the ports is a ratio select that changes in the middle of a 16-cycle period. Here the output must keep its old ratio until the boundary, and must never produce a short pulse. The stimulus rewrites `sel_i` every few source cycles at offsets that are not aligned to the boundary. A bench model latches the select only at multiples of 16 and predicts every sample. High impedance is made visible with pull-ups on the pins, because the internal level during reset is 0. The sweep covers all sixteen select codes with both feedback ratios, and it also covers bypass from each reference.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  // log2 of the low division ratio per output class
  localparam int PRI_SHIFT = 1;
  localparam int SEC_SHIFT = 2;
  localparam int FB_SHIFT  = 3;
  localparam int CNT_W     = FB_SHIFT + 1;
  localparam int NUM_SEC   = 3;
  // bit positions inside the 4-bit select code
  localparam int SEL_A = 3;
  localparam int SEL_B = 2;
  localparam int SEL_C = 1;
  localparam int SEL_D = 0;
endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux (
  input  logic vco_clk_i,
  input  logic xtal_clk_i,
  input  logic test_clk_i,
  input  logic ref_sel_i,
  input  logic pll_en_i,
  output logic ref_clk_o,
  output logic div_clk_o
);
  assign ref_clk_o = ref_sel_i ? test_clk_i : xtal_clk_i;
  assign div_clk_o = pll_en_i ? vco_clk_i : ref_clk_o;
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  // reset to all ones so the first edge after release lands on zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '1;
    else         cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = &cnt_o;
endmodule

// File: rtl/div_tap.sv
module div_tap #(
  parameter int CNT_W = 4,
  parameter int SHIFT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             slow_i,
  output logic             out_o
);
  localparam int LO_BIT = SHIFT - 1;
  localparam int HI_BIT = SHIFT;
  localparam logic [CNT_W-1:0] LO_MASK = CNT_W'((1 << LO_BIT) - 1);
  localparam logic [CNT_W-1:0] HI_MASK = CNT_W'((1 << HI_BIT) - 1);

  logic             sel_q;
  logic             sel_eff;
  logic [CNT_W-1:0] cnt_nxt;
  logic             out_d;

  assign sel_eff = wrap_i ? slow_i : sel_q;
  assign cnt_nxt = cnt_i + 1'b1;
  assign out_d   = sel_eff ? ~cnt_nxt[HI_BIT] : ~cnt_nxt[LO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      out_o <= 1'b0;
    end else begin
      if (wrap_i) sel_q <= slow_i;
      out_o <= out_d;
    end
  end

  // R10
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(sel_q));
  // R6
  rise_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> out_o);
  // R6
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> ((cnt_i & (sel_q ? HI_MASK : LO_MASK)) == '0));
endmodule

// File: rtl/out_drv.sv
module out_drv #(
  parameter int W = 1
) (
  input  logic         in_i,
  input  logic         oe_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign out_o[i] = oe_i ? in_i : 1'bz;
  end
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clk_div_pkg::*;
#(
  parameter int NUM_C = 2,
  parameter int NUM_D = 5
) (
  input  logic             rst_ni,
  input  logic             vco_clk_i,
  input  logic             xtal_clk_i,
  input  logic             test_clk_i,
  input  logic             ref_sel_i,
  input  logic             pll_en_i,
  input  logic             mr_oe_i,
  input  logic             fb_sel_i,
  input  logic [3:0]       sel_i,
  output logic             ref_clk_o,
  output logic             fb_o,
  output logic             qa_o,
  output logic             qb_o,
  output logic [NUM_C-1:0] qc_o,
  output logic [NUM_D-1:0] qd_o
);
  logic             div_clk;
  logic             arst_n;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             qa_int;
  logic [NUM_SEC-1:0] sec_int;
  logic [NUM_SEC-1:0] sec_slow;

  assign arst_n = rst_ni & ~mr_oe_i;

  clk_src_mux u_src (
    .vco_clk_i (vco_clk_i),
    .xtal_clk_i(xtal_clk_i),
    .test_clk_i(test_clk_i),
    .ref_sel_i (ref_sel_i),
    .pll_en_i  (pll_en_i),
    .ref_clk_o (ref_clk_o),
    .div_clk_o (div_clk)
  );

  div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (div_clk),
    .rst_ni(arst_n),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  div_tap #(.CNT_W(CNT_W), .SHIFT(PRI_SHIFT)) u_tap_a (
    .clk_i (div_clk),
    .rst_ni(arst_n),
    .cnt_i (cnt),
    .wrap_i(wrap),
    .slow_i(sel_i[SEL_A]),
    .out_o (qa_int)
  );

  assign sec_slow = {sel_i[SEL_B], sel_i[SEL_C], sel_i[SEL_D]};

  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    div_tap #(.CNT_W(CNT_W), .SHIFT(SEC_SHIFT)) u_tap (
      .clk_i (div_clk),
      .rst_ni(arst_n),
      .cnt_i (cnt),
      .wrap_i(wrap),
      .slow_i(sec_slow[g]),
      .out_o (sec_int[g])
    );
  end

  // feedback select high picks the shorter ratio
  div_tap #(.CNT_W(CNT_W), .SHIFT(FB_SHIFT)) u_tap_fb (
    .clk_i (div_clk),
    .rst_ni(arst_n),
    .cnt_i (cnt),
    .wrap_i(wrap),
    .slow_i(~fb_sel_i),
    .out_o (fb_o)
  );

  out_drv #(.W(1))     u_drv_a (.in_i(qa_int),     .oe_i(~mr_oe_i), .out_o(qa_o));
  out_drv #(.W(1))     u_drv_b (.in_i(sec_int[2]), .oe_i(~mr_oe_i), .out_o(qb_o));
  out_drv #(.W(NUM_C)) u_drv_c (.in_i(sec_int[1]), .oe_i(~mr_oe_i), .out_o(qc_o));
  out_drv #(.W(NUM_D)) u_drv_d (.in_i(sec_int[0]), .oe_i(~mr_oe_i), .out_o(qd_o));

  // R7
  fb_held_chk: assert property (@(posedge div_clk) disable iff (!rst_ni)
    mr_oe_i |=> !fb_o);
endmodule

// File: tb/clk_div_bank_tb.sv
module clk_div_bank_tb;
  localparam int NC = 2;
  localparam int ND = 5;

  logic rst_n = 0, vco = 0, xclk = 0, tclk = 0;
  logic rsel = 0, pll = 1, mr = 1, fbs = 0;
  logic [3:0] sel = 4'h0;
  wire ref_w, fb_w, qa_w, qb_w;
  wire [NC-1:0] qc_w;
  wire [ND-1:0] qd_w;
  logic dclk;
  int n_chk = 0, n_fail = 0;
  logic done = 0;

  always #5  vco  = ~vco;
  always #15 xclk = ~xclk;
  always #35 tclk = ~tclk;

  assign dclk = pll ? vco : (rsel ? tclk : xclk);

  pullup (qa_w);
  pullup (qb_w);
  for (genvar i = 0; i < NC; i++) begin : g_pc
    pullup (qc_w[i]);
  end
  for (genvar i = 0; i < ND; i++) begin : g_pd
    pullup (qd_w[i]);
  end

  clk_div_bank #(.NUM_C(NC), .NUM_D(ND)) u_dut (
    .rst_ni(rst_n), .vco_clk_i(vco), .xtal_clk_i(xclk), .test_clk_i(tclk),
    .ref_sel_i(rsel), .pll_en_i(pll), .mr_oe_i(mr), .fb_sel_i(fbs),
    .sel_i(sel), .ref_clk_o(ref_w), .fb_o(fb_w), .qa_o(qa_w), .qb_o(qb_w),
    .qc_o(qc_w), .qd_o(qd_w)
  );

  task automatic chk(input logic act, input logic exp, input string req,
                     input string tag, input int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s k=%0d actual=%b expected=%b", req, tag, k, act, exp);
    end
  endtask

  function automatic logic wave(input int n, input int k);
    return (k % n) < (n / 2);
  endfunction

  // step > 0: sel advances every step cycles, off the 16-cycle grid (R10)
  task automatic run_case(input logic [3:0] s0, input logic fb, input logic p,
                          input logic rs, input int ncyc, input int step,
                          input string tag);
    logic [3:0] eff;
    logic [3:0] cur;
    mr = 1; pll = p; rsel = rs; fbs = fb; sel = s0;
    repeat (3) @(negedge dclk);
    // R7: pins float (pulled up), feedback low, while held
    chk(qa_w, 1'b1, "R7", tag, -1);
    chk(qb_w, 1'b1, "R7", tag, -1);
    chk(&qc_w, 1'b1, "R7", tag, -1);
    chk(&qd_w, 1'b1, "R7", tag, -1);
    chk(fb_w, 1'b0, "R7", tag, -1);
    mr = 0;
    eff = s0;
    for (int k = 0; k < ncyc; k++) begin
      cur = (step > 0) ? 4'(s0 + 4'(k / step)) : s0;
      sel = cur;
      if (k % 16 == 0) eff = cur;
      @(negedge dclk);
      chk(qa_w, wave(eff[3] ? 4 : 2, k), "R1", tag, k);
      chk(qb_w, wave(eff[2] ? 8 : 4, k), "R2", tag, k);
      for (int i = 0; i < NC; i++) chk(qc_w[i], wave(eff[1] ? 8 : 4, k), "R3", tag, k);
      for (int i = 0; i < ND; i++) chk(qd_w[i], wave(eff[0] ? 8 : 4, k), "R4", tag, k);
      chk(fb_w, wave(fb ? 8 : 16, k), "R5", tag, k);
    end
  endtask

  task automatic ref_check(input logic rs, input logic p);
    mr = 1; rsel = rs; pll = p;
    @(posedge vco);
    #1;
    for (int i = 0; i < 20; i++) begin
      chk(ref_w, rs ? tclk : xclk, "R9", "ref", i);
      #5;
    end
  endtask

  initial begin
    #22 rst_n = 1;
    // R1-related sweep over every select code, both feedback ratios (R6 alignment)
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 2; f++) begin
        run_case(4'(s), 1'(f), 1'b1, 1'b0, 32, 0, "sweep");
      end
    end
    // R10: select changes mid-period
    run_case(4'h0, 1'b1, 1'b1, 1'b0, 64, 5, "midchg_a");
    run_case(4'h9, 1'b0, 1'b1, 1'b0, 64, 3, "midchg_b");
    // R8: bypass from crystal and from test clock
    run_case(4'h5, 1'b1, 1'b0, 1'b0, 32, 0, "R8_xtal");
    run_case(4'hA, 1'b0, 1'b0, 1'b1, 32, 0, "R8_test");
    run_case(4'hF, 1'b1, 1'b0, 1'b1, 16, 0, "R8_test2");
    // R9: reference select seen at ref_clk_o
    ref_check(1'b0, 1'b1);
    ref_check(1'b1, 1'b1);
    ref_check(1'b1, 1'b0);
    ref_check(1'b0, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule